// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers six interrupt requests for a small processor core. The sources are an external edge input, a high-speed timer overflow, two general timer overflows, a time-base tick and a speech-end event. Each request pulse sets a per-source latch. Software can clear a latch but can never set one. Every source except the external input is gated by its own mask bit, and all sources are gated by a global enable flip-flop. A fixed-priority encoder picks one winner among the eligible latches. The controller then presents a pending flag and a 13-bit entry address to the core.

The core acknowledges the presented request. On that acknowledge the controller clears the winner's latch and drops the global enable. It also forces the core's status flag to 1 for the same cycle. A return-from-interrupt strobe sets the global enable again, so nested acceptance is held off until the handler returns. Software can also write the enable directly. Once presented, the pending flag and the address are frozen until the acknowledge, so the core can sample them at any point before it answers.

Source index (0 to 5): 0 external input, 1 high-speed timer, 2 timer A, 3 timer B, 4 time base, 5 speech.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `irq_pending_o` is 1, `vector_o` equals 2*(i+1) for winning source i, giving 002h, 004h, 006h, 008h, 00Ah and 00Ch. While `irq_pending_o` is 0, `vector_o` is 000h, the reset entry.
- R2: A 1 on `req_i[i]` in a cycle sets latch i on that clock edge. A write with `clr_wr_i`=1 clears every latch whose bit in `clr_bits_i` is 1. A clear write never sets a latch. `latch_o` shows the latches.
- R3: Source i is eligible only when latch i is 1 and `enable_o` is 1. For i>0, mask bit i-1 (written from `mask_wdata_i` when `mask_wr_i`=1) must also be 1, where 1 permits. Source 0 ignores the masks.
- R4: An `ack_i`=1 while `irq_pending_o`=1 clears the winner's latch and clears `enable_o` on that edge, drives `sf_force_o` to 1 in that same cycle, and drops `irq_pending_o` in the next cycle.
- R5: `rti_i`=1 sets `enable_o` on the next edge. A write with `ei_wr_i`=1 loads `ei_wdata_i` into the enable.
- R6: After reset, `enable_o`, all mask bits, all latches, `irq_pending_o` and `vector_o` are 0.
- R7: Among eligible sources, the lowest index wins.
- R8: Once `irq_pending_o` is 1, it and `vector_o` hold their values until an acknowledge, even if a higher-priority request arrives.
- R9: A request on the same edge as a software clear or an acknowledge of its own latch leaves that latch set.
- R10: An `ack_i` while `irq_pending_o` is 0 changes no latch and not the enable.
- R11: `irq_pending_o` rises one cycle after the latch of an eligible source sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_SRC | Hardware request pulses, one per source |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | NUM_SRC-1 | Mask bits for sources 1..NUM_SRC-1, 1 permits |
| clr_wr_i | input | 1 | Latch clear strobe |
| clr_bits_i | input | NUM_SRC | Latches to clear |
| ei_wr_i | input | 1 | Global enable write strobe |
| ei_wdata_i | input | 1 | Value written to the global enable |
| rti_i | input | 1 | Return-from-interrupt strobe |
| ack_i | input | 1 | Core acknowledge |
| irq_pending_o | output | 1 | A request is presented |
| vector_o | output | VEC_W | Entry address of the presented request |
| sf_force_o | output | 1 | Forces the status flag to 1 on acceptance |
| latch_o | output | NUM_SRC | Request latch contents |
| enable_o | output | 1 | Global enable flip-flop |

## Verification
The bench builds the block with its default parameters: six sources and a 13-bit vector with base and stride of 2. With these values every entry address from 002h to 00Ch, the unmasked external source and all five masked sources can be reached directly. The scoreboard predicts the address of each acknowledged request. Directed sequences cover priority between coincident latches, the freeze of a presented vector against a later higher-priority request, set-wins-over-clear collisions, and acknowledges with no pending request.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_SRC    = 6,
  parameter int VEC_W      = 13,
  parameter int VEC_BASE   = 2,
  parameter int VEC_STRIDE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               mask_wr_i,
  input  logic [NUM_SRC-2:0] mask_wdata_i,
  input  logic               clr_wr_i,
  input  logic [NUM_SRC-1:0] clr_bits_i,
  input  logic               ei_wr_i,
  input  logic               ei_wdata_i,
  input  logic               rti_i,
  input  logic               ack_i,
  output logic               irq_pending_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic               sf_force_o,
  output logic [NUM_SRC-1:0] latch_o,
  output logic               enable_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] latch_q;
  logic [NUM_SRC-2:0] mask_q;
  logic               en_q;
  logic               pend_q;
  logic [VEC_W-1:0]   vec_q;
  logic [IDX_W-1:0]   win_q;

  logic [NUM_SRC-1:0] elig;
  logic               cand_v;
  logic [IDX_W-1:0]   cand_idx;
  logic               take;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] ack_vec;

  assign take    = ack_i & pend_q;
  assign clr_vec = clr_wr_i ? clr_bits_i : '0;
  assign ack_vec = take ? (NUM_SRC'(1) << win_q) : '0;
  assign elig    = latch_q & {mask_q, 1'b1} & {NUM_SRC{en_q}};

  always_comb begin
    cand_v   = 1'b0;
    cand_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        cand_v   = 1'b1;
        cand_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      mask_q  <= '0;
      en_q    <= 1'b0;
    end else begin
      latch_q <= (latch_q & ~clr_vec & ~ack_vec) | req_i;
      if (mask_wr_i) mask_q <= mask_wdata_i;
      if (take)         en_q <= 1'b0;
      else if (rti_i)   en_q <= 1'b1;
      else if (ei_wr_i) en_q <= ei_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
      win_q  <= '0;
    end else if (take) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else if (!pend_q) begin
      pend_q <= cand_v;
      win_q  <= cand_idx;
      vec_q  <= cand_v ? VEC_W'(VEC_BASE + int'(cand_idx) * VEC_STRIDE) : '0;
    end
  end

  assign irq_pending_o = pend_q;
  assign vector_o      = vec_q;
  assign sf_force_o    = take;
  assign latch_o       = latch_q;
  assign enable_o      = en_q;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NUM_SRC = 6,
  parameter int VEC_W   = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic               rti_i,
  input logic               ack_i,
  input logic               irq_pending_o,
  input logic [VEC_W-1:0]   vector_o,
  input logic               sf_force_o,
  input logic [NUM_SRC-1:0] latch_o,
  input logic               enable_o
);
  p_vec_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending_o |-> (vector_o != '0 && vector_o[0] == 1'b0));

  p_idle_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pending_o |-> vector_o == '0);

  p_req_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_i != '0 |=> (latch_o & $past(req_i)) == $past(req_i));

  p_no_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch_o & ~$past(latch_o)) & ~$past(req_i)) == '0);

  p_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_pending_o) |=> (!enable_o && !irq_pending_o));

  p_sf_only_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sf_force_o |-> (ack_i && irq_pending_o));

  p_rti_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_i && !(ack_i && irq_pending_o)) |=> enable_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending_o && !ack_i) |=> (irq_pending_o && $stable(vector_o)));

  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_pending_o && !rti_i) |=> $stable(enable_o) || enable_o);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .rti_i(rti_i), .ack_i(ack_i),
  .irq_pending_o(irq_pending_o), .vector_o(vector_o), .sf_force_o(sf_force_o),
  .latch_o(latch_o), .enable_o(enable_o)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  localparam int N = 6;
  localparam int VW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_i = '0;
  logic mask_wr_i = 1'b0;
  logic [N-2:0] mask_wdata_i = '0;
  logic clr_wr_i = 1'b0;
  logic [N-1:0] clr_bits_i = '0;
  logic ei_wr_i = 1'b0;
  logic ei_wdata_i = 1'b0;
  logic rti_i = 1'b0;
  logic ack_i = 1'b0;
  logic irq_pending_o;
  logic [VW-1:0] vector_o;
  logic sf_force_o;
  logic [N-1:0] latch_o;
  logic enable_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_wr_i(mask_wr_i),
    .mask_wdata_i(mask_wdata_i), .clr_wr_i(clr_wr_i), .clr_bits_i(clr_bits_i),
    .ei_wr_i(ei_wr_i), .ei_wdata_i(ei_wdata_i), .rti_i(rti_i), .ack_i(ack_i),
    .irq_pending_o(irq_pending_o), .vector_o(vector_o), .sf_force_o(sf_force_o),
    .latch_o(latch_o), .enable_o(enable_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_req(input logic [N-1:0] bits);
    req_i = bits;
    tick();
    req_i = '0;
  endtask

  task automatic rti();
    rti_i = 1'b1;
    tick();
    rti_i = 1'b0;
  endtask

  // driver side of the scoreboard: predict, then acknowledge
  task automatic take(input int exp_vec, input string tag);
    int w = 0;
    exp_q.push_back(exp_vec);
    while (!irq_pending_o && w < 10) begin tick(); w++; end
    check(irq_pending_o == 1'b1, tag, irq_pending_o, 1);
    ack_i = 1'b1;
    #1;
    check(sf_force_o == 1'b1, "R4 sf_force", sf_force_o, 1);
    @(negedge clk);
    ack_i = 1'b0;
    check(irq_pending_o == 1'b0, "R4 pending drop", irq_pending_o, 0);
    check(enable_o == 1'b0, "R4 enable drop", enable_o, 0);
  endtask

  // monitor side: compare presented vector at acceptance
  always begin
    @(negedge clk);
    #1;
    if (rst_n && ack_i && irq_pending_o) begin
      if (exp_q.size() == 0)
        check(1'b0, "R1 unexpected accept", vector_o, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(vector_o == VW'(e), "R1 R7 vector", vector_o, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_pending_o == 0 && vector_o == 0, "R6 reset outputs", {irq_pending_o, vector_o}, 0);
    check(latch_o == 0 && enable_o == 0, "R6 reset state", {latch_o, enable_o}, 0);

    pulse_req(6'b000100);
    check(latch_o == 6'b000100, "R2 latch set", latch_o, 6'b000100);
    tick();
    check(irq_pending_o == 0, "R3 enable gates", irq_pending_o, 0);

    ei_wr_i = 1'b1; ei_wdata_i = 1'b1; tick(); ei_wr_i = 1'b0;
    check(enable_o == 1, "R5 ei write", enable_o, 1);
    tick();
    check(irq_pending_o == 0, "R3 mask gates", irq_pending_o, 0);

    pulse_req(6'b000001);
    check(irq_pending_o == 0, "R11 one cycle latency", irq_pending_o, 0);
    tick();
    check(irq_pending_o == 1 && vector_o == 13'h002, "R3 unmasked source", vector_o, 13'h002);
    take(2, "R1 ext");
    check(latch_o == 6'b000100, "R4 winner latch clear", latch_o, 6'b000100);

    ack_i = 1'b1; tick(); ack_i = 1'b0;
    check(latch_o == 6'b000100 && enable_o == 0, "R10 idle ack", {latch_o, enable_o}, {6'b000100, 1'b0});

    clr_wr_i = 1'b1; clr_bits_i = 6'b000100; tick();
    clr_bits_i = 6'b000010; tick(); clr_wr_i = 1'b0; clr_bits_i = '0;
    check(latch_o == 0, "R2 clear only", latch_o, 0);

    mask_wr_i = 1'b1; mask_wdata_i = '1; tick(); mask_wr_i = 1'b0;
    rti();
    check(enable_o == 1, "R5 rti", enable_o, 1);
    pulse_req(6'b101000);
    tick();
    check(vector_o == 13'h008, "R7 priority", vector_o, 13'h008);
    take(8, "R7 first");
    rti();
    take(12, "R7 second");

    clr_wr_i = 1'b1; clr_bits_i = 6'b010000; req_i = 6'b010000; tick();
    clr_wr_i = 1'b0; clr_bits_i = '0; req_i = '0;
    check(latch_o == 6'b010000, "R9 set wins", latch_o, 6'b010000);
    rti();
    tick();
    check(vector_o == 13'h00A, "R1 time base", vector_o, 13'h00A);
    pulse_req(6'b000001);
    tick(); tick();
    check(irq_pending_o == 1 && vector_o == 13'h00A, "R8 held vector", vector_o, 13'h00A);
    take(10, "R8 accept");
    rti();
    take(2, "R8 later ext");

    for (int i = 0; i < N; i++) begin
      rti();
      pulse_req(N'(1) << i);
      take((i + 1) * 2, "R1 each source");
    end

    mask_wr_i = 1'b1; mask_wdata_i = 5'b11011; tick(); mask_wr_i = 1'b0;
    rti();
    pulse_req(6'b001000);
    tick(); tick();
    check(irq_pending_o == 0, "R3 masked timer B", irq_pending_o, 0);
    check(latch_o == 6'b001000, "R3 latch kept", latch_o, 6'b001000);

    check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule